// File: doc/BRIEF.md
# Flash Operation Capability Screen

This block decides whether a serial flash controller can carry out a proposed memory operation. Each operation is described by the lane width of its command, address, dummy and data phases, the byte counts of the address, dummy and data phases, and the direction of the data phase. On a valid strobe the block classifies the operation and returns two verdicts one clock later: whether it qualifies for the accelerated page-transfer path, and whether the controller supports it at all.

Page transfers may use wide lanes, but only in fixed pairings. On a page read the width of the data phase follows the width of the address phase, and the dummy phase is limited by the number of clock cycles it takes rather than by its byte count. A page write must be narrow on the address phase and may use one or four data lanes. Any other operation is accepted only if every phase that is present runs on a single lane. The command phase must always be single-lane.

The verdicts are registered and stay in place until the next strobe. A one-cycle completion pulse marks each new result.

Top module: `flash_op_screen`

## Requirements
- R1: During reset and on the first cycle after it, `done`, `page_op` and `supported` are all 0.
- R2: The cycle after `op_valid` is high, `done` is 1 and both verdicts reflect the inputs sampled with the strobe. In a cycle after `op_valid` was low, `done` is 0 and both verdicts keep their previous values, whatever the other inputs do.
- R3: When `cmd_lanes` is not 1, `supported` is 0, whatever the other fields hold.
- R4: `page_op` is 1 only when `addr_bytes` is exactly 2, `addr_lanes` is 1, 2 or 4, and `data_dir` is 01 (read) or 10 (write). The codes 00 (no data) and 11 (reserved) never give a page operation.
- R5: For a page read, the dummy cycle count floor(`dummy_bytes` × 8 ÷ `dummy_lanes`) must be at most 15. When `dummy_bytes` is 0 the dummy width does not matter. When `dummy_lanes` is 0 and `dummy_bytes` is non-zero, the operation is not a page operation.
- R6: For a page read, 4 address lanes require 4 data lanes and 2 address lanes require 2 data lanes. A 1-lane address allows 1, 2 or 4 data lanes.
- R7: A page write requires `dummy_bytes` to be 0, `addr_lanes` to be 1, and `data_lanes` to be 1 or 4.
- R8: `supported` = (`cmd_lanes` is 1) AND (`page_op` OR every present phase has lane width 1). A phase is present when its byte count is non-zero. `page_op` does not depend on `cmd_lanes`. All lane fields are plain binary lane counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Strobe: operation descriptor is valid this cycle |
| cmd_lanes | input | LANE_W (3) | Lane count of the command phase |
| addr_lanes | input | LANE_W (3) | Lane count of the address phase |
| addr_bytes | input | ABYTE_W (3) | Byte count of the address phase |
| dummy_lanes | input | LANE_W (3) | Lane count of the dummy phase |
| dummy_bytes | input | DBYTE_W (4) | Byte count of the dummy phase |
| data_lanes | input | LANE_W (3) | Lane count of the data phase |
| data_len | input | DLEN_W (16) | Byte count of the data phase |
| data_dir | input | 2 | 00 none, 01 read, 10 write, 11 reserved |
| done | output | 1 | One-cycle pulse when a new verdict is presented |
| page_op | output | 1 | Operation qualifies for the page-transfer path |
| supported | output | 1 | Operation can be executed by the controller |

## Verification
The hardest case to reach is a page read whose dummy phase sits exactly at the cycle limit. One dummy byte on one lane (8 cycles) passes, and two bytes on one lane (16 cycles) fails. A three-lane dummy phase takes truncated division, and a zero-width dummy phase with bytes present must be rejected without dividing. The sweep crosses every dummy byte count from 0 to 2 with every dummy width from 0 to 4, and crosses these with all address and data lane pairings and all four direction codes, so each of these edges is visited under both read and write. Between strobes the bench scrambles every input and checks that the held verdicts do not move.

// File: rtl/fos_pkg.sv
package fos_pkg;

    typedef enum logic [1:0] {
        DIR_NONE = 2'b00,
        DIR_IN   = 2'b01,
        DIR_OUT  = 2'b10,
        DIR_RSVD = 2'b11
    } xfer_dir_e;

    typedef struct packed {
        logic page;
        logic sup;
    } verdict_t;

    localparam int unsigned LANES_SINGLE = 1;
    localparam int unsigned LANES_DUAL   = 2;
    localparam int unsigned LANES_QUAD   = 4;

    // Lane count belongs to the set a page path can drive (1, 2 or 4)
    function automatic logic std_lanes(input int unsigned n);
        return (n == LANES_SINGLE) || (n == LANES_DUAL) || (n == LANES_QUAD);
    endfunction

endpackage

// File: rtl/fos_read_rule.sv
module fos_read_rule
    import fos_pkg::*;
#(
    parameter int LANE_W        = 3,
    parameter int DBYTE_W       = 4,
    parameter int MAX_DUMMY_CYC = 15
) (
    input  logic [LANE_W-1:0]  addr_lanes,
    input  logic [LANE_W-1:0]  dummy_lanes,
    input  logic [DBYTE_W-1:0] dummy_bytes,
    input  logic [LANE_W-1:0]  data_lanes,
    output logic               ok
);
    localparam int CYC_W = DBYTE_W + 3;

    logic [CYC_W-1:0] dummy_bits;
    logic [CYC_W-1:0] divisor;
    logic [CYC_W-1:0] dummy_cyc;
    logic             dummy_ok;
    logic             lanes_ok;

    always_comb begin
        dummy_bits = {dummy_bytes, 3'b000};
        // A zero divisor is replaced; that case is rejected separately
        divisor    = (dummy_lanes == '0) ? CYC_W'(1)
                                         : {{(CYC_W-LANE_W){1'b0}}, dummy_lanes};
        dummy_cyc  = dummy_bits / divisor;
        if (dummy_bytes == '0)
            dummy_ok = 1'b1;
        else if (dummy_lanes == '0)
            dummy_ok = 1'b0;
        else
            dummy_ok = (dummy_cyc <= CYC_W'(MAX_DUMMY_CYC));
    end

    always_comb begin
        if (int'(addr_lanes) == LANES_QUAD)
            lanes_ok = (int'(data_lanes) == LANES_QUAD);
        else if (int'(addr_lanes) == LANES_DUAL)
            lanes_ok = (int'(data_lanes) == LANES_DUAL);
        else if (int'(addr_lanes) == LANES_SINGLE)
            lanes_ok = std_lanes(int'(data_lanes));
        else
            lanes_ok = 1'b0;
    end

    assign ok = dummy_ok && lanes_ok;

endmodule

// File: rtl/fos_write_rule.sv
module fos_write_rule
    import fos_pkg::*;
#(
    parameter int LANE_W  = 3,
    parameter int DBYTE_W = 4
) (
    input  logic [LANE_W-1:0]  addr_lanes,
    input  logic [DBYTE_W-1:0] dummy_bytes,
    input  logic [LANE_W-1:0]  data_lanes,
    output logic               ok
);
    logic data_ok;

    assign data_ok = (int'(data_lanes) == LANES_SINGLE) ||
                     (int'(data_lanes) == LANES_QUAD);
    assign ok = (dummy_bytes == '0) &&
                (int'(addr_lanes) == LANES_SINGLE) &&
                data_ok;

endmodule

// File: rtl/fos_plain_rule.sv
module fos_plain_rule
    import fos_pkg::*;
#(
    parameter int LANE_W = 3,
    parameter int NPH    = 3
) (
    input  logic [NPH-1:0]             present,
    input  logic [NPH-1:0][LANE_W-1:0] lanes,
    output logic                       ok
);
    logic [NPH-1:0] phase_ok;

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        assign phase_ok[p] = !present[p] || (int'(lanes[p]) == LANES_SINGLE);
    end

    assign ok = &phase_ok;

endmodule

// File: rtl/flash_op_screen.sv
module flash_op_screen
    import fos_pkg::*;
#(
    parameter int LANE_W          = 3,
    parameter int ABYTE_W         = 3,
    parameter int DBYTE_W         = 4,
    parameter int DLEN_W          = 16,
    parameter int PAGE_ADDR_BYTES = 2,
    parameter int MAX_DUMMY_CYC   = 15
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               op_valid,
    input  logic [LANE_W-1:0]  cmd_lanes,
    input  logic [LANE_W-1:0]  addr_lanes,
    input  logic [ABYTE_W-1:0] addr_bytes,
    input  logic [LANE_W-1:0]  dummy_lanes,
    input  logic [DBYTE_W-1:0] dummy_bytes,
    input  logic [LANE_W-1:0]  data_lanes,
    input  logic [DLEN_W-1:0]  data_len,
    input  logic [1:0]         data_dir,
    output logic               done,
    output logic               page_op,
    output logic               supported
);
    localparam int NPH = 3;

    xfer_dir_e dir;
    logic      rd_ok;
    logic      wr_ok;
    logic      plain_ok;
    logic      addr_shape_ok;
    verdict_t  next_v;
    verdict_t  held_v;

    logic [NPH-1:0]             ph_present;
    logic [NPH-1:0][LANE_W-1:0] ph_lanes;

    assign dir = xfer_dir_e'(data_dir);

    fos_read_rule #(
        .LANE_W        (LANE_W),
        .DBYTE_W       (DBYTE_W),
        .MAX_DUMMY_CYC (MAX_DUMMY_CYC)
    ) u_read (
        .addr_lanes  (addr_lanes),
        .dummy_lanes (dummy_lanes),
        .dummy_bytes (dummy_bytes),
        .data_lanes  (data_lanes),
        .ok          (rd_ok)
    );

    fos_write_rule #(
        .LANE_W  (LANE_W),
        .DBYTE_W (DBYTE_W)
    ) u_write (
        .addr_lanes  (addr_lanes),
        .dummy_bytes (dummy_bytes),
        .data_lanes  (data_lanes),
        .ok          (wr_ok)
    );

    assign ph_present = {(data_len != '0), (dummy_bytes != '0), (addr_bytes != '0)};
    assign ph_lanes   = {data_lanes, dummy_lanes, addr_lanes};

    fos_plain_rule #(
        .LANE_W (LANE_W),
        .NPH    (NPH)
    ) u_plain (
        .present (ph_present),
        .lanes   (ph_lanes),
        .ok      (plain_ok)
    );

    assign addr_shape_ok = (addr_bytes == ABYTE_W'(PAGE_ADDR_BYTES)) &&
                           std_lanes(int'(addr_lanes));

    always_comb begin
        unique case (dir)
            DIR_IN:  next_v.page = addr_shape_ok && rd_ok;
            DIR_OUT: next_v.page = addr_shape_ok && wr_ok;
            default: next_v.page = 1'b0;
        endcase
        next_v.sup = (int'(cmd_lanes) == LANES_SINGLE) && (next_v.page || plain_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_v <= '0;
            done   <= 1'b0;
        end else begin
            done <= op_valid;
            if (op_valid)
                held_v <= next_v;
        end
    end

    assign page_op   = held_v.page;
    assign supported = held_v.sup;

endmodule

// File: rtl/fos_checker.sv
module fos_checker #(
    parameter int LANE_W          = 3,
    parameter int ABYTE_W         = 3,
    parameter int DBYTE_W         = 4,
    parameter int PAGE_ADDR_BYTES = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               op_valid,
    input logic [LANE_W-1:0]  cmd_lanes,
    input logic [LANE_W-1:0]  addr_lanes,
    input logic [ABYTE_W-1:0] addr_bytes,
    input logic [LANE_W-1:0]  dummy_lanes,
    input logic [DBYTE_W-1:0] dummy_bytes,
    input logic [LANE_W-1:0]  data_lanes,
    input logic [1:0]         data_dir,
    input logic               done,
    input logic               page_op,
    input logic               supported
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!done && !page_op && !supported));

    // R2
    done_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> done);

    // R2
    no_done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !done);

    // R2
    verdict_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(page_op) && $stable(supported)));

    // R3
    wide_cmd_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && cmd_lanes != LANE_W'(1)) |=> !supported);

    // R4
    page_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (addr_bytes != ABYTE_W'(PAGE_ADDR_BYTES) ||
                      data_dir == 2'b00 || data_dir == 2'b11)) |=> !page_op);

    // R5
    zero_dummy_width_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && dummy_bytes != '0 && dummy_lanes == '0) |=> !page_op);

    // R6
    quad_addr_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && data_dir == 2'b01 && addr_lanes == LANE_W'(4) &&
         data_lanes != LANE_W'(4)) |=> !page_op);

    // R7
    write_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && data_dir == 2'b10 &&
         (dummy_bytes != '0 || addr_lanes != LANE_W'(1))) |=> !page_op);

    // R8
    page_implies_sup_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && cmd_lanes == LANE_W'(1)) |=> (!page_op || supported));

endmodule

bind flash_op_screen fos_checker #(
    .LANE_W          (LANE_W),
    .ABYTE_W         (ABYTE_W),
    .DBYTE_W         (DBYTE_W),
    .PAGE_ADDR_BYTES (PAGE_ADDR_BYTES)
) u_fos_checker (
    .clk         (clk),
    .rst         (rst),
    .op_valid    (op_valid),
    .cmd_lanes   (cmd_lanes),
    .addr_lanes  (addr_lanes),
    .addr_bytes  (addr_bytes),
    .dummy_lanes (dummy_lanes),
    .dummy_bytes (dummy_bytes),
    .data_lanes  (data_lanes),
    .data_dir    (data_dir),
    .done        (done),
    .page_op     (page_op),
    .supported   (supported)
);

// File: tb/test_flash_op_screen.sv
module test_flash_op_screen;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [2:0]  cmd_lanes;
    logic [2:0]  addr_lanes;
    logic [2:0]  addr_bytes;
    logic [2:0]  dummy_lanes;
    logic [3:0]  dummy_bytes;
    logic [2:0]  data_lanes;
    logic [15:0] data_len;
    logic [1:0]  data_dir;
    logic        done;
    logic        page_op;
    logic        supported;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    flash_op_screen i_flash_op_screen (
        .clk         (clk),
        .rst         (rst),
        .op_valid    (op_valid),
        .cmd_lanes   (cmd_lanes),
        .addr_lanes  (addr_lanes),
        .addr_bytes  (addr_bytes),
        .dummy_lanes (dummy_lanes),
        .dummy_bytes (dummy_bytes),
        .data_lanes  (data_lanes),
        .data_len    (data_len),
        .data_dir    (data_dir),
        .done        (done),
        .page_op     (page_op),
        .supported   (supported)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    function automatic logic is124(input int n);
        return n == 1 || n == 2 || n == 4;
    endfunction

    // Expected page flag from R4..R7
    function automatic logic exp_page(input int aw, input int ab, input int dw,
                                      input int db, input int ww, input int dir);
        if (ab != 2 || !is124(aw)) return 1'b0;
        if (dir == 1) begin
            if (db != 0) begin
                if (dw == 0) return 1'b0;
                if ((db * 8) / dw > 15) return 1'b0;
            end
            if (aw == 4) return ww == 4;
            if (aw == 2) return ww == 2;
            return is124(ww);
        end
        if (dir == 2) return db == 0 && aw == 1 && (ww == 1 || ww == 4);
        return 1'b0;
    endfunction

    // Expected supported flag from R3 and R8
    function automatic logic exp_sup(input int cw, input logic pg, input int aw,
                                     input int ab, input int dw, input int db,
                                     input int ww, input int dl);
        logic plain;
        plain = (ab == 0 || aw == 1) && (db == 0 || dw == 1) && (dl == 0 || ww == 1);
        return cw == 1 && (pg || plain);
    endfunction

    task automatic run_vec(input int cw, input int aw, input int ab, input int dw,
                           input int db, input int ww, input int dl, input int dir);
        logic ep, es;
        ep = exp_page(aw, ab, dw, db, ww, dir);
        es = exp_sup(cw, ep, aw, ab, dw, db, ww, dl);
        cmd_lanes   = 3'(cw);
        addr_lanes  = 3'(aw);
        addr_bytes  = 3'(ab);
        dummy_lanes = 3'(dw);
        dummy_bytes = 4'(db);
        data_lanes  = 3'(ww);
        data_len    = 16'(dl);
        data_dir    = 2'(dir);
        op_valid    = 1'b1;
        @(negedge clk);
        check(done, 1'b1, "R2 done pulse");
        check(page_op, ep, "R4 R5 R6 R7 page flag");
        check(supported, es, "R3 R8 supported flag");
        // Scramble every input with the strobe low: nothing may move (R2)
        op_valid    = 1'b0;
        cmd_lanes   = 3'(cw + 3);
        addr_lanes  = 3'(aw + 1);
        addr_bytes  = 3'(ab ^ 2);
        dummy_lanes = 3'(dw + 5);
        dummy_bytes = 4'(db + 7);
        data_lanes  = 3'(ww + 2);
        data_len    = 16'(dl ^ 5);
        data_dir    = 2'(dir + 1);
        @(negedge clk);
        check(done, 1'b0, "R2 done idle");
        check(page_op, ep, "R2 page hold");
        check(supported, es, "R2 supported hold");
    endtask

    initial begin
        rst = 1'b1;
        op_valid = 1'b0;
        cmd_lanes = 3'd1; addr_lanes = 3'd1; addr_bytes = 3'd2;
        dummy_lanes = 3'd1; dummy_bytes = 4'd0; data_lanes = 3'd1;
        data_len = 16'd0; data_dir = 2'b01;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(done, 1'b0, "R1 done in reset");
        check(page_op, 1'b0, "R1 page in reset");
        check(supported, 1'b0, "R1 supported in reset");
        rst = 1'b0;
        @(negedge clk);
        check(done, 1'b0, "R1 done after reset");
        check(page_op, 1'b0, "R1 page after reset");
        check(supported, 1'b0, "R1 supported after reset");

        // Directed boundary cases: R5 limit, R6 pairing, R7 write, R3 command
        run_vec(1, 1, 2, 1, 1, 4, 8, 1);   // R5 8 cycles: page
        run_vec(1, 1, 2, 1, 2, 4, 8, 1);   // R5 16 cycles: not page
        run_vec(1, 4, 2, 4, 7, 4, 8, 1);   // R5 14 cycles quad: page
        run_vec(1, 2, 2, 1, 0, 4, 8, 1);   // R6 dual addr, quad data: no
        run_vec(1, 1, 2, 1, 0, 4, 8, 2);   // R7 quad write: page
        run_vec(1, 1, 2, 1, 0, 2, 8, 2);   // R7 dual write: no
        run_vec(2, 1, 2, 1, 0, 1, 8, 1);   // R3 wide command: unsupported

        // Near-exhaustive sweep (R2..R8)
        for (int cw = 1; cw <= 2; cw++)
            for (int aw = 0; aw <= 4; aw++)
                for (int ai = 0; ai < 3; ai++)
                    for (int dw = 0; dw <= 4; dw++)
                        for (int db = 0; db <= 2; db++)
                            for (int ww = 0; ww <= 4; ww++)
                                for (int li = 0; li < 2; li++)
                                    for (int dir = 0; dir < 4; dir++)
                                        run_vec(cw, aw, (ai == 0) ? 0 : ai + 1,
                                                dw, db, ww, li * 3, dir);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule